// File: doc/BRIEF.md
# RGBW Colour Command Receiver

This block sits behind a UART receiver on a serial bus that several driver boards share. It takes the received bytes one at a time and groups them into fixed ten-byte command packets. Each packet holds a command byte, a logical channel number and four 16-bit colour words. The block checks the command and the channel. When a packet is accepted, it drives a single write that places all four colour words into the local brightness register file, at the raw slots of the addressed output.

There is no delimiter byte. Framing recovers through an idle timeout: if no good byte arrives for a set number of time-base ticks, the byte position returns to the start of a packet. Each board owns a window of eight logical channels that begins at its channel offset, and it ignores packets addressed outside that window. The colour words are rotated by one slot so that their order matches the connector wiring.

Top module: `rgbw_cmd_rx`

## Requirements
- R1: A packet is ten good bytes in this order: command, channel, then four words of two bytes each. When the tenth byte is taken and the packet is accepted, `wr_en` is high for exactly one cycle, in the cycle after that byte is sampled. There is exactly one pulse for each accepted packet.
- R2: A packet is accepted only when its command byte is 0x23. For any other command value, `wr_en` stays low.
- R3: A packet is accepted only when its channel byte c satisfies CH_OFFSET <= c < CH_OFFSET + NUM_LOGICAL. For any other channel value, `wr_en` stays low.
- R4: On an accepted write, `wr_base` equals (c - CH_OFFSET) * SLOTS_PER_CH, which is the first raw slot of the addressed output.
- R5: Each colour word is big-endian. Its first received byte is bits 15:8 and its second is bits 7:0.
- R6: Raw slot k is carried on `wr_data[16k+15:16k]`. Word 0 goes to slot 1, word 1 to slot 2, word 2 to slot 3 and word 3 to slot 0.
- R7: A byte presented with `rx_overrun` high is discarded. It does not advance the byte position and does not restart the idle timeout.
- R8: Every good byte restarts the idle timeout. If TIMEOUT_TICKS `tick` pulses then occur with no good byte, the byte position returns to 0. With fewer pulses, the position is kept.
- R9: After every tenth byte the byte position returns to 0, whether or not the packet was accepted. The next packet therefore frames correctly.
- R10: After reset, `wr_en` is low and the byte position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rx_overrun | input | 1 | The receiver lost data; the byte offered this cycle is to be dropped |
| tick | input | 1 | Time-base strobe (one pulse per microsecond in the target system) |
| wr_en | output | 1 | Register file write strobe, four slots at once |
| wr_base | output | 5 | First raw slot of the write (always a multiple of 4) |
| wr_data | output | 64 | Four 16-bit slot values, slot k in bits 16k+15:16k |

## Verification
The bench builds the block with a channel offset of 16 and an idle timeout of 6 ticks. The offset of 16 places the accept window at channels 16 to 23. A sweep over all 256 channel bytes then crosses both edges of the window, and a sweep over all 256 command bytes probes every identifier. The short timeout makes it cheap to test the case one tick short of expiry and the case of exact expiry. It also allows a check that an overrun byte between these two points does not reset the timer.

// File: rtl/rgbw_rx_pkg.sv
package rgbw_rx_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam logic [BYTE_W-1:0] CMD_SET_COLOUR = 8'h23;

  // Raw slot that receives colour word w (rotation by one matching the connector).
  function automatic int slot_for_word(input int w, input int slots);
    return (w + 1) % slots;
  endfunction

  // Channel byte lies inside this board's window of logical outputs.
  function automatic logic chan_in_window(input logic [BYTE_W-1:0] ch,
                                          input int offset, input int count);
    int c;
    c = int'({24'd0, ch});
    return (c >= offset) && (c < offset + count);
  endfunction

  // First raw slot belonging to a logical channel.
  function automatic int raw_base(input logic [BYTE_W-1:0] ch,
                                  input int offset, input int slots);
    int c;
    c = int'({24'd0, ch});
    return (c - offset) * slots;
  endfunction

endpackage

// File: rtl/rgbw_rx_framer.sv
module rgbw_rx_framer #(
  parameter int PKT_BYTES     = 10,
  parameter int TIMEOUT_TICKS = 1000,
  parameter int POS_W         = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_overrun,
  input  logic             tick,
  output logic             byte_take,
  output logic             pkt_last,
  output logic             timeout_fire,
  output logic [POS_W-1:0] pos
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(TIMEOUT_TICKS - 1);

  logic [CNT_W-1:0] idle_cnt;
  logic             armed;

  assign byte_take    = rx_valid && !rx_overrun;
  assign pkt_last     = byte_take && (pos == LAST_POS);
  assign timeout_fire = !byte_take && armed && tick && (idle_cnt == CNT_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      idle_cnt <= '0;
      armed    <= 1'b0;
    end else if (byte_take) begin
      pos      <= pkt_last ? '0 : pos + 1'b1;
      idle_cnt <= '0;
      armed    <= 1'b1;
    end else if (armed && tick) begin
      if (timeout_fire) begin
        pos      <= '0;
        idle_cnt <= '0;
        armed    <= 1'b0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rgbw_rx_collect.sv
module rgbw_rx_collect #(
  parameter int PKT_BYTES = 10,
  parameter int POS_W     = $clog2(PKT_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_take,
  input  logic [POS_W-1:0]       pos,
  input  logic [7:0]             rx_data,
  output logic [8*PKT_BYTES-1:0] pkt_flat
);
  // Bytes 0..PKT_BYTES-2 are held; the final byte is taken straight from the input.
  logic [7:0] store_q [PKT_BYTES-1];

  for (genvar g = 0; g < PKT_BYTES - 1; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (!rst_n)
        store_q[g] <= '0;
      else if (byte_take && (pos == POS_W'(g)))
        store_q[g] <= rx_data;
    end
    assign pkt_flat[8*g +: 8] = store_q[g];
  end

  assign pkt_flat[8*(PKT_BYTES-1) +: 8] = rx_data;
endmodule

// File: rtl/rgbw_rx_decode.sv
module rgbw_rx_decode #(
  parameter int CH_OFFSET   = 8,
  parameter int NUM_LOGICAL = 8,
  parameter int SLOTS       = 4,
  parameter int RAW_AW      = 5,
  parameter int PKT_BYTES   = 2 + 2 * SLOTS
) (
  input  logic [8*PKT_BYTES-1:0] pkt_flat,
  output logic                   accept,
  output logic [RAW_AW-1:0]      base,
  output logic [16*SLOTS-1:0]    slot_data
);
  import rgbw_rx_pkg::*;

  logic [7:0] cmd_byte;
  logic [7:0] chan_byte;

  assign cmd_byte  = pkt_flat[7:0];
  assign chan_byte = pkt_flat[15:8];

  assign accept = (cmd_byte == CMD_SET_COLOUR) &&
                  chan_in_window(chan_byte, CH_OFFSET, NUM_LOGICAL);
  assign base   = RAW_AW'(raw_base(chan_byte, CH_OFFSET, SLOTS));

  for (genvar w = 0; w < SLOTS; w++) begin : g_word
    localparam int SLOT = slot_for_word(w, SLOTS);
    assign slot_data[WORD_W*SLOT +: WORD_W] =
      {pkt_flat[8*(2+2*w) +: 8], pkt_flat[8*(3+2*w) +: 8]};
  end
endmodule

// File: rtl/rgbw_cmd_rx.sv
module rgbw_cmd_rx #(
  parameter int CH_OFFSET     = 8,
  parameter int NUM_LOGICAL   = 8,
  parameter int SLOTS_PER_CH  = 4,
  parameter int TIMEOUT_TICKS = 1000,
  localparam int NUM_RAW      = NUM_LOGICAL * SLOTS_PER_CH,
  localparam int RAW_AW       = $clog2(NUM_RAW),
  localparam int DATA_W       = 16 * SLOTS_PER_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_overrun,
  input  logic              tick,
  output logic              wr_en,
  output logic [RAW_AW-1:0] wr_base,
  output logic [DATA_W-1:0] wr_data
);
  localparam int PKT_BYTES = 2 + 2 * SLOTS_PER_CH;
  localparam int POS_W     = $clog2(PKT_BYTES);

  // Named internal events, also observed by the bound checker.
  logic                   byte_take;
  logic                   pkt_last;
  logic                   timeout_fire;
  logic [POS_W-1:0]       pos;
  logic [8*PKT_BYTES-1:0] pkt_flat;
  logic                   accept;
  logic [RAW_AW-1:0]      dec_base;
  logic [DATA_W-1:0]      dec_data;
  logic                   commit;

  rgbw_rx_framer #(
    .PKT_BYTES(PKT_BYTES), .TIMEOUT_TICKS(TIMEOUT_TICKS), .POS_W(POS_W)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_overrun(rx_overrun),
    .tick(tick), .byte_take(byte_take), .pkt_last(pkt_last),
    .timeout_fire(timeout_fire), .pos(pos)
  );

  rgbw_rx_collect #(.PKT_BYTES(PKT_BYTES), .POS_W(POS_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .byte_take(byte_take), .pos(pos),
    .rx_data(rx_data), .pkt_flat(pkt_flat)
  );

  rgbw_rx_decode #(
    .CH_OFFSET(CH_OFFSET), .NUM_LOGICAL(NUM_LOGICAL), .SLOTS(SLOTS_PER_CH),
    .RAW_AW(RAW_AW), .PKT_BYTES(PKT_BYTES)
  ) u_decode (
    .pkt_flat(pkt_flat), .accept(accept), .base(dec_base), .slot_data(dec_data)
  );

  assign commit = pkt_last && accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_base <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= commit;
      if (commit) begin
        wr_base <= dec_base;
        wr_data <= dec_data;
      end
    end
  end
endmodule

// File: rtl/rgbw_cmd_rx_chk.sv
module rgbw_cmd_rx_chk #(
  parameter int PKT_BYTES = 10,
  parameter int POS_W     = 4,
  parameter int DATA_W    = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_overrun,
  input logic [7:0]        rx_data,
  input logic              byte_take,
  input logic              pkt_last,
  input logic              timeout_fire,
  input logic [POS_W-1:0]  pos,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data
);
  localparam logic [POS_W-1:0] LAST = POS_W'(PKT_BYTES - 1);

  // R9: the position never leaves the packet length
  assert_pos_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);

  // R9: the tenth byte wraps the position
  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && pos == LAST) |=> pos == '0);

  // R1: a good byte inside a packet advances by one
  assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && pos != LAST) |=> pos == $past(pos) + 1'b1);

  // R7: an overrun byte leaves the position alone
  assert_overrun_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_overrun && !timeout_fire) |=> $stable(pos));

  // R8: expiry returns the framing to the start
  assert_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_fire |=> pos == '0);

  // R1: the write strobe is a single-cycle pulse
  assert_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R1: a write always follows a completed packet
  assert_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(pkt_last));

  // R6: the final byte (word 3 low byte) lands in slot 0 low byte
  assert_last_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data[7:0] == $past(rx_data));
endmodule

bind rgbw_cmd_rx rgbw_cmd_rx_chk #(
  .PKT_BYTES(PKT_BYTES), .POS_W(POS_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_overrun(rx_overrun),
  .rx_data(rx_data), .byte_take(byte_take), .pkt_last(pkt_last),
  .timeout_fire(timeout_fire), .pos(pos), .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/rgbw_cmd_rx_test.sv
`timescale 1ns/1ps
module rgbw_cmd_rx_test;
  localparam int OFF = 16;
  localparam int NL  = 8;
  localparam int SL  = 4;
  localparam int TO  = 6;
  localparam int PKT = 10;
  localparam int AW  = 5;
  localparam int DW  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic rx_overrun = 1'b0;
  logic tick = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic wr_en;
  logic [AW-1:0] wr_base;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  int wr_seen = 0;
  int wr_expect = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rgbw_cmd_rx #(.CH_OFFSET(OFF), .NUM_LOGICAL(NL), .SLOTS_PER_CH(SL),
                .TIMEOUT_TICKS(TO)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_overrun(rx_overrun), .tick(tick), .wr_en(wr_en), .wr_base(wr_base),
    .wr_data(wr_data)
  );

  always @(negedge clk) if (rst_n && wr_en) wr_seen++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkwords(input int seed);
    logic [15:0] s;
    s = 16'(seed);
    return {16'hA000 ^ s, 16'h0B00 + s, 16'(s * 16'd7), ~s};
  endfunction

  function automatic logic [7:0] pbyte(input logic [7:0] cmd, input logic [7:0] ch,
                                       input logic [63:0] words, input int i);
    logic [15:0] w;
    if (i == 0) return cmd;
    if (i == 1) return ch;
    w = words[16*((i-2)/2) +: 16];
    return ((i % 2) == 0) ? w[15:8] : w[7:0];
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit ovr);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_overrun = ovr;
    @(negedge clk);
    rx_valid = 1'b0; rx_overrun = 1'b0;
  endtask

  task automatic send_range(input logic [7:0] cmd, input logic [7:0] ch,
                            input logic [63:0] words, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) send_byte(pbyte(cmd, ch, words, i), 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  // Called at the negedge right after the last byte's sampling edge.
  task automatic check_out(input string req, input bit exp_en,
                           input logic [7:0] ch, input logic [63:0] words);
    int eb;
    chk(wr_en == exp_en, req, "write strobe", 64'(wr_en), 64'(exp_en));
    if (exp_en) begin
      wr_expect++;
      eb = (int'({24'd0, ch}) - OFF) * SL;
      chk(int'({27'd0, wr_base}) == eb, "R4", "slot base", 64'(wr_base), 64'(eb));
      for (int s = 0; s < SL; s++)
        chk(wr_data[16*s +: 16] == words[16*((s + SL - 1) % SL) +: 16], "R6",
            $sformatf("slot %0d", s), 64'(wr_data[16*s +: 16]),
            64'(words[16*((s + SL - 1) % SL) +: 16]));
    end
  endtask

  initial begin
    logic [63:0] w;
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R10", "strobe in reset", 64'(wr_en), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_en == 1'b0, "R10", "strobe after reset", 64'(wr_en), 64'd0);

    // R10: first packet after reset frames from byte 0
    w = mkwords(77);
    send_range(8'h23, 8'(OFF), w, 0, PKT-1);
    check_out("R10", 1'b1, 8'(OFF), w);

    // R3 / R9: every channel byte, rejected packets must not disturb framing
    for (int c = 0; c < 256; c++) begin
      w = mkwords(c);
      send_range(8'h23, 8'(c), w, 0, PKT-1);
      check_out("R3", (c >= OFF) && (c < OFF + NL), 8'(c), w);
    end

    // R2: every command byte on an in-window channel
    for (int k = 0; k < 256; k++) begin
      w = mkwords(k + 1000);
      send_range(8'(k), 8'(OFF + 1), w, 0, PKT-1);
      check_out("R2", k == 'h23, 8'(OFF + 1), w);
    end

    // R5: byte order inside a word
    w = {16'hDEAD, 16'hBEEF, 16'h5A3C, 16'h1234};
    send_range(8'h23, 8'(OFF + 7), w, 0, PKT-1);
    check_out("R5", 1'b1, 8'(OFF + 7), w);
    chk(wr_data[31:16] == 16'h1234, "R5", "word0 high byte first",
        64'(wr_data[31:16]), 64'h1234);
    chk(wr_base == 5'd28, "R4", "top channel base", 64'(wr_base), 64'd28);

    // R9: rejected packet followed directly by an accepted one
    w = mkwords(5);
    send_range(8'h24, 8'(OFF + 2), w, 0, PKT-1);
    check_out("R9", 1'b0, 8'(OFF + 2), w);
    send_range(8'h23, 8'(OFF + 2), w, 0, PKT-1);
    check_out("R9", 1'b1, 8'(OFF + 2), w);

    // R7: overrun byte in the middle of a packet is dropped
    w = mkwords(321);
    send_range(8'h23, 8'(OFF + 3), w, 0, 4);
    send_byte(8'hEE, 1'b1);
    send_range(8'h23, 8'(OFF + 3), w, 5, PKT-1);
    check_out("R7", 1'b1, 8'(OFF + 3), w);

    // R8: one tick short of expiry keeps the partial packet
    w = mkwords(444);
    send_range(8'h23, 8'(OFF + 4), w, 0, 2);
    ticks(TO - 1);
    send_range(8'h23, 8'(OFF + 4), w, 3, PKT-1);
    check_out("R8", 1'b1, 8'(OFF + 4), w);

    // R8: full expiry discards a stray fragment
    send_byte(8'h23, 1'b0); send_byte(8'h11, 1'b0); send_byte(8'h22, 1'b0);
    ticks(TO);
    w = mkwords(555);
    send_range(8'h23, 8'(OFF + 5), w, 0, PKT-1);
    check_out("R8", 1'b1, 8'(OFF + 5), w);

    // R7: overrun byte does not restart the idle timeout
    send_byte(8'h23, 1'b0); send_byte(8'h33, 1'b0); send_byte(8'h44, 1'b0);
    ticks(TO - 2);
    send_byte(8'h99, 1'b1);
    ticks(2);
    w = mkwords(666);
    send_range(8'h23, 8'(OFF + 6), w, 0, PKT-1);
    check_out("R7", 1'b1, 8'(OFF + 6), w);

    repeat (3) @(negedge clk);
    chk(wr_seen == wr_expect, "R1", "write pulse cycles", 64'(wr_seen), 64'(wr_expect));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule